// File: doc/BRIEF.md
# Masked Byte Compare Unit

This block compares a chosen subset of the bytes of a register operand with a run of consecutive bytes held in memory. A mask has one bit per register byte. The mask's leftmost bit belongs to the most significant byte. The bytes whose mask bit is set are packed into one contiguous field. That field is compared with memory, starting at a base address and moving to higher addresses one byte at a time.

The comparison is unsigned. The result is a two-bit condition code that reports equal, lower or higher for the register field. Work runs under a start/busy/done handshake. The unit reads memory through a simple port: it raises a read request with an address, and the byte comes back on the following cycle. It stops reading at the first byte pair that differs. The unit does no instruction decode, no address arithmetic beyond stepping, and no fault handling.

Top module: `masked_byte_cmp`

## Requirements
- R1: Mask bit i selects register byte i, where byte NUM_BYTES-1 is the most significant byte and belongs to the leftmost mask bit. An unselected byte takes part in no comparison and causes no memory read.
- R2: The selected bytes are taken from the most significant to the least significant. The k-th selected byte (k counted from 0) is compared with the byte read at base address + k.
- R3: The condition code on `cc` is 0 when all compared pairs are equal, 1 when the register byte of the first unequal pair is lower, and 2 when it is higher. The comparison treats bytes as unsigned, so 0xFF is higher than 0x7F.
- R4: After a byte pair differs, no further read request is issued before `done`.
- R5: A mask of all zeros issues no read request, and `done` follows on the cycle after start with `cc` = 0.
- R6: At most one read is outstanding at a time. `rd_data` is taken on the cycle after `rd_req`, and `rd_req` is never high on two cycles in a row.
- R7: `busy` is high from the cycle after an accepted start through the `done` cycle. `done` is a single-cycle pulse, and `cc` holds its value from `done` until the next accepted start.
- R8: A `start` raised while `busy` is high is ignored. It changes neither the result nor the number of reads of the run in progress, and it produces no extra `done`.
- R9: While reset is held and right after it is released, `busy`, `done` and `rd_req` are low and `cc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a comparison; accepted only when idle |
| opnd | input | NUM_BYTES*BYTE_W | Register operand |
| mask | input | NUM_BYTES | Byte select mask; the leftmost bit belongs to the most significant byte |
| base_addr | input | ADDR_W | Address of the first memory byte |
| busy | output | 1 | A comparison is in progress |
| done | output | 1 | One-cycle completion pulse |
| cc | output | 2 | Condition code: 0 equal, 1 lower, 2 higher |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | ADDR_W | Memory read address |
| rd_data | input | BYTE_W | Read data, valid the cycle after `rd_req` |

## Verification
The bench builds the unit with four 8-bit bytes and a 12-bit address. A 256-byte model is enough to reach every mask pattern, from empty to full, with base addresses near the top of that window. With these sizes, a vector table can state each mask shape, unsigned ordering and early mismatch exactly. The bench counts requests per run and checks every address against the base plus the selected-byte index. The directed tests cover the reset state, a start raised during a run, and the single-cycle done pulse.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

   typedef enum logic [1:0] {
      CC_EQ   = 2'd0,
      CC_LOW  = 2'd1,
      CC_HIGH = 2'd2
   } cc_t;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ISSUE,
      ST_CHECK,
      ST_DONE
   } st_t;

endpackage

// File: rtl/mbc_pick.sv
module mbc_pick #(
   parameter int NB         = 4,
   parameter int IW         = 2,
   parameter bit LEFT_FIRST = 1'b1
) (
   input  logic [NB-1:0] pend,
   output logic          found,
   output logic [IW-1:0] idx
);

   assign found = |pend;

   generate
      if (LEFT_FIRST) begin : g_left
         // highest set index wins: later loop iterations overwrite
         always_comb begin
            idx = '0;
            for (int i = 0; i < NB; i++) begin
               if (pend[i]) idx = IW'(i);
            end
         end
      end else begin : g_right
         always_comb begin
            idx = '0;
            for (int i = NB - 1; i >= 0; i--) begin
               if (pend[i]) idx = IW'(i);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/mbc_bytecmp.sv
module mbc_bytecmp
   import mbc_pkg::*;
#(
   parameter int BW = 8
) (
   input  logic [BW-1:0] a,
   input  logic [BW-1:0] b,
   output logic          ne,
   output cc_t           res
);

   always_comb begin
      ne = (a != b);
      if (a < b)      res = CC_LOW;
      else if (a > b) res = CC_HIGH;
      else            res = CC_EQ;
   end

endmodule

// File: rtl/mbc_ctrl.sv
module mbc_ctrl
   import mbc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic mask_zero,
   input  logic byte_ne,
   input  logic last,
   output st_t  state
);

   st_t state_nx;

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:  if (start) state_nx = mask_zero ? ST_DONE : ST_ISSUE;
         ST_ISSUE: state_nx = ST_CHECK;
         ST_CHECK: state_nx = (byte_ne || last) ? ST_DONE : ST_ISSUE;
         ST_DONE:  state_nx = ST_IDLE;
         default:  state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nx;
   end

   // R4
   mismatch_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CHECK && byte_ne) |=> (state == ST_DONE));

endmodule

// File: rtl/masked_byte_cmp.sv
module masked_byte_cmp
   import mbc_pkg::*;
#(
   parameter int NUM_BYTES  = 4,
   parameter int BYTE_W     = 8,
   parameter int ADDR_W     = 24,
   parameter bit LEFT_FIRST = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic [NUM_BYTES*BYTE_W-1:0] opnd,
   input  logic [NUM_BYTES-1:0]        mask,
   input  logic [ADDR_W-1:0]           base_addr,
   output logic                        busy,
   output logic                        done,
   output logic [1:0]                  cc,
   output logic                        rd_req,
   output logic [ADDR_W-1:0]           rd_addr,
   input  logic [BYTE_W-1:0]           rd_data
);

   localparam int REG_W = NUM_BYTES * BYTE_W;
   localparam int IDX_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

   generate
      if (NUM_BYTES < 1 || NUM_BYTES > 16) begin : g_bad_nb
         $error("NUM_BYTES must lie in 1..16");
      end
      if (BYTE_W < 1) begin : g_bad_bw
         $error("BYTE_W must be positive");
      end
      if (ADDR_W < 1) begin : g_bad_aw
         $error("ADDR_W must be positive");
      end
   endgenerate

   st_t                  state;
   logic [REG_W-1:0]     opnd_q;
   logic [NUM_BYTES-1:0] pend_q;
   logic [NUM_BYTES-1:0] pend_nx;
   logic [ADDR_W-1:0]    addr_q;
   cc_t                  cc_q;
   logic                 accept;
   logic                 found;
   logic [IDX_W-1:0]     idx;
   logic [BYTE_W-1:0]    opbyte [NUM_BYTES];
   logic [BYTE_W-1:0]    sel_byte;
   logic                 byte_ne;
   cc_t                  byte_res;
   logic                 last;

   assign accept = (state == ST_IDLE) && start;

   genvar g;
   generate
      for (g = 0; g < NUM_BYTES; g++) begin : g_bytes
         assign opbyte[g] = opnd_q[g*BYTE_W +: BYTE_W];
      end
   endgenerate

   mbc_pick #(.NB(NUM_BYTES), .IW(IDX_W), .LEFT_FIRST(LEFT_FIRST)) u_pick (
      .pend  (pend_q),
      .found (found),
      .idx   (idx)
   );

   assign sel_byte = opbyte[idx];

   mbc_bytecmp #(.BW(BYTE_W)) u_cmp (
      .a   (sel_byte),
      .b   (rd_data),
      .ne  (byte_ne),
      .res (byte_res)
   );

   always_comb begin
      pend_nx      = pend_q;
      pend_nx[idx] = 1'b0;
   end

   assign last = (pend_nx == '0);

   mbc_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .mask_zero (mask == '0),
      .byte_ne   (byte_ne),
      .last      (last),
      .state     (state)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         opnd_q <= '0;
         pend_q <= '0;
         addr_q <= '0;
         cc_q   <= CC_EQ;
      end else if (accept) begin
         opnd_q <= opnd;
         pend_q <= mask;
         addr_q <= base_addr;
         cc_q   <= CC_EQ;
      end else if (state == ST_CHECK) begin
         if (byte_ne) begin
            cc_q <= byte_res;
         end else begin
            pend_q <= pend_nx;
            addr_q <= addr_q + ADDR_W'(1);
         end
      end
   end

   assign busy    = (state != ST_IDLE);
   assign done    = (state == ST_DONE);
   assign rd_req  = (state == ST_ISSUE);
   assign rd_addr = addr_q;
   assign cc      = cc_q;

   // R6
   req_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req);

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3
   cc_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cc != 2'b11));

   // R5
   empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && mask == '0) |=> (done && cc == 2'd0 && !rd_req));

   // R1
   issue_has_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> found);

   // R8
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && start) |=> busy);

   // R7
   cc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(done) && !busy) |-> $stable(cc));

endmodule

// File: tb/tb_masked_byte_cmp.sv
module tb_masked_byte_cmp;

   localparam int NB = 4;
   localparam int BW = 8;
   localparam int AW = 12;
   localparam int NV = 8;

   // {opnd, mask, base, mem bytes from base upward, cc, reads}
   localparam logic [80:0] VEC [NV] = '{
      {32'hF0BC5C7B, 4'hD, 8'd10,  32'hF0BC7B00, 2'd0, 3'd3}, // R1 skip one byte, equal
      {32'h00000001, 4'hF, 8'd40,  32'h00000002, 2'd1, 3'd4}, // R3 lower in last byte
      {32'hFF000000, 4'h8, 8'd80,  32'h7F000000, 2'd2, 3'd1}, // R3 unsigned higher
      {32'h12345678, 4'h0, 8'd90,  32'h12345678, 2'd0, 3'd0}, // R5 empty mask
      {32'h11223344, 4'h6, 8'd100, 32'h22340000, 2'd1, 3'd2}, // R2 middle bytes
      {32'hAABBCCDD, 4'hF, 8'd120, 32'hAA000000, 2'd2, 3'd2}, // R4 early stop
      {32'h00000080, 4'h1, 8'd200, 32'h80000000, 2'd0, 3'd1}, // R1 low byte only
      {32'h01020304, 4'hF, 8'd250, 32'h02000000, 2'd1, 3'd1}  // R4 first byte differs
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [31:0]   opnd = '0;
   logic [NB-1:0] mask = '0;
   logic [AW-1:0] base_addr = '0;
   logic          busy, done, rd_req;
   logic [1:0]    cc;
   logic [AW-1:0] rd_addr;
   logic [BW-1:0] rd_data = '0;

   logic [7:0]    mem [256];
   int            checks = 0;
   int            errors = 0;
   int            rd_total = 0;
   int            addr_errs = 0;
   int            snap = 0;
   int            cur_base = 0;

   always #10 clk = ~clk;

   masked_byte_cmp #(.NUM_BYTES(NB), .BYTE_W(BW), .ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .opnd(opnd), .mask(mask),
      .base_addr(base_addr), .busy(busy), .done(done), .cc(cc),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   always @(posedge clk) begin
      if (rd_req) begin
         rd_data <= mem[rd_addr[7:0]];
         if (int'(rd_addr) != cur_base + (rd_total - snap)) addr_errs <= addr_errs + 1;
         rd_total <= rd_total + 1;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wait_done(output bit seen);
      seen = 1'b0;
      for (int i = 0; i < 60 && !seen; i++) begin
         @(negedge clk);
         if (done) seen = 1'b1;
      end
   endtask

   task automatic run(input logic [31:0] op, input logic [3:0] mk, input int base,
                      input logic [31:0] mb, input int exp_cc, input int exp_rd,
                      input string tag);
      bit seen;
      int aerr0;
      for (int k = 0; k < 4; k++) mem[(base + k) % 256] = mb[31 - 8*k -: 8];
      @(negedge clk);
      snap = rd_total;
      aerr0 = addr_errs;
      cur_base = base;
      opnd = op; mask = mk; base_addr = AW'(base); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk({tag, " R7 busy"}, int'(busy), 1);
      if (!done) wait_done(seen); else seen = 1'b1;
      chk({tag, " done seen"}, int'(seen), 1);
      chk({tag, " R3 cc"}, int'(cc), exp_cc);
      chk({tag, " R4 reads"}, rd_total - snap, exp_rd);
      chk({tag, " R2 addr"}, addr_errs - aerr0, 0);
      @(negedge clk);
      chk({tag, " R7 done pulse"}, int'(done), 0);
      chk({tag, " R7 cc hold"}, int'(cc), exp_cc);
   endtask

   initial begin
      #4ms;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      bit seen;
      int r0;
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      // R9 during reset
      chk("R9 busy in reset", int'(busy), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 busy", int'(busy), 0);
      chk("R9 done", int'(done), 0);
      chk("R9 rd_req", int'(rd_req), 0);
      chk("R9 cc", int'(cc), 0);

      for (int v = 0; v < NV; v++) begin
         run(VEC[v][80:49], VEC[v][48:45], int'(VEC[v][44:37]), VEC[v][36:5],
             int'(VEC[v][4:3]), int'(VEC[v][2:0]), $sformatf("vec%0d", v));
      end

      // R5 empty mask: done on first cycle after start
      @(negedge clk);
      snap = rd_total;
      opnd = 32'hFFFFFFFF; mask = 4'h0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R5 done next cycle", int'(done), 1);
      chk("R5 cc", int'(cc), 0);
      chk("R5 no reads", rd_total - snap, 0);
      @(negedge clk);

      // R8 start while busy is ignored
      for (int k = 0; k < 4; k++) mem[16 + k] = 8'h55;
      snap = rd_total;
      cur_base = 16;
      r0 = addr_errs;
      opnd = 32'h55555555; mask = 4'hF; base_addr = AW'(16); start = 1'b1;
      @(negedge clk);
      opnd = 32'h00000000; mask = 4'h0; base_addr = AW'(0);
      @(negedge clk);
      @(negedge clk);
      start = 1'b0;
      wait_done(seen);
      chk("R8 done", int'(seen), 1);
      chk("R8 cc", int'(cc), 0);
      chk("R8 reads", rd_total - snap, 4);
      chk("R8 addr", addr_errs - r0, 0);
      r0 = 0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (done) r0++;
      end
      chk("R8 no extra done", r0, 0);
      chk("R8 idle", int'(busy), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule